// File: doc/BRIEF.md
# CAM Search Key Generator

This block produces the stimulus for exercising a 64-row, 18-bit content addressable memory. After a start request it first fills the memory: a single-cycle write strobe marks the first of 64 consecutive clock cycles. In each of those cycles it presents one pseudo-random word on the data bus. The words come from an 18-bit maximal-length shift register. The block keeps a private copy of every word it loads, so it can later replay exact hit keys.

Without a pause it then moves on to searching. It presents one key per clock, taken from one of four schedules chosen by a 2-bit mode input that is captured at start:
- a sparse schedule with one hit per 64 keys;
- a dense schedule with one miss per 64 keys;
- an alternating hit/miss schedule;
- a free-running pseudo-random schedule.

Miss keys are later states of the same shift register, which cannot coincide with any loaded word within one period of the register. The search phase lasts until reset.

Top module: `cam_keygen`

## Requirements
- R1: After reset, and until start is sampled high, phase_o is 0 (idle), wr_o is 0 and data_o is 0.
- R2: On the clock that samples start high in idle, phase_o becomes 1 (load) for exactly 64 cycles. data_o carries the shift register words S0..S63, where S0 is the seed (default 18'h1ACE5). Each S(n+1) is S(n) shifted one place toward the MSB, with bit0 set to bit17 XOR bit10 of S(n). wr_o is 1 only in the cycle that shows S0.
- R3: phase_o becomes 2 (search) in the cycle right after the one showing S63, and it stays 2 until reset. In that first cycle data_o is the key for search index k=0. k counts the search cycles from 0.
- R4: Mode 0 (sparse): when k mod 64 = 0 the key is stored word number (k mod 128)/2. Otherwise it is the miss key S(64 + (k mod 128)).
- R5: Mode 1 (dense): when k mod 64 = 63 the key is the miss key S(64 + (k mod 128)). Otherwise it is stored word number k mod 64.
- R6: Mode 2 (alternating): when k is even the key is stored word number (k mod 128)/2. When k is odd it is the miss key S(64 + (k mod 128)).
- R7: In modes 0 to 2 the key sequence repeats every 128 searches, and no miss key equals any loaded word. Every aligned 64-key block therefore holds 1 (mode 0), 63 (mode 1) or 32 (mode 2) stored words.
- R8: Mode 3 (random): the key at search index k is S(64 + k), so the shift register keeps stepping once per cycle with no wrap at 128.
- R9: The mode is captured only when start is sampled in idle. Changes on start and mode during load or search do not alter the outputs.
- R10: The internal shift register never holds zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begins loading when sampled high in idle |
| mode | input | 2 | Search schedule: 0 sparse, 1 dense, 2 alternating, 3 random |
| wr_o | output | 1 | Single-cycle write strobe at the first loaded word |
| data_o | output | 18 | Load word or search key |
| phase_o | output | 2 | 0 idle, 1 load, 2 search |

## Verification
The embedded assertions check these properties on every cycle:
- the strobe lasts one cycle and only appears in load;
- the outputs stay quiet in idle;
- load lasts exactly 64 cycles and search never ends;
- the captured mode stays fixed once idle is left;
- the shift register stays nonzero.

Only the bench's per-mode scenarios can show the remaining properties. These are the exact word and key values, the hit and miss positions, the 128-search repetition, the absence of miss keys from the stored set, and the immunity of a running sequence to start and mode activity. The bench compares every output cycle of all four modes against an arithmetic model, over more than two full key periods.

// File: rtl/cam_keygen_pkg.sv
package cam_keygen_pkg;

    localparam int KEY_W    = 18;
    localparam int TAP_HI   = 18;
    localparam int TAP_LO   = 11;
    localparam int ROW_W    = 6;
    localparam int ROWS     = 1 << ROW_W;
    localparam int PERIOD_W = ROW_W + 1;

    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,
        PH_LOAD   = 2'd1,
        PH_SEARCH = 2'd2
    } phase_e;

    typedef enum logic [1:0] {
        MD_SPARSE = 2'd0,
        MD_DENSE  = 2'd1,
        MD_HALF   = 2'd2,
        MD_RAND   = 2'd3
    } mode_e;

    typedef struct packed {
        logic             hit;
        logic [ROW_W-1:0] idx;
    } pick_t;

    function automatic logic [KEY_W-1:0] lfsr_step(input logic [KEY_W-1:0] s);
        logic fb;
        fb = s[TAP_HI-1] ^ s[TAP_LO-1];
        return {s[KEY_W-2:0], fb};
    endfunction

endpackage

// File: rtl/cam_keygen_lfsr.sv
module cam_keygen_lfsr
    import cam_keygen_pkg::*;
#(
    parameter logic [KEY_W-1:0] SEED = 18'h1ACE5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             advance,
    input  logic             reload,
    input  logic [KEY_W-1:0] reload_val,
    output logic [KEY_W-1:0] state
);

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= SEED;
        end else if (reload) begin
            state <= reload_val;
        end else if (advance) begin
            state <= lfsr_step(state);
        end
    end

    // R10: a zero state would lock the register forever
    a_r10_never_zero: assert property (@(posedge clk) disable iff (rst)
        state != '0);

endmodule

// File: rtl/cam_keygen_store.sv
module cam_keygen_store
    import cam_keygen_pkg::*;
(
    input  logic             clk,
    input  logic             we,
    input  logic [ROW_W-1:0] waddr,
    input  logic [KEY_W-1:0] wdata,
    input  logic [ROW_W-1:0] raddr,
    output logic [KEY_W-1:0] rdata
);

    logic [KEY_W-1:0] mem [ROWS];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
    end

    assign rdata = mem[raddr];

endmodule

// File: rtl/cam_keygen_sched.sv
module cam_keygen_sched
    import cam_keygen_pkg::*;
(
    input  mode_e               mode,
    input  logic [PERIOD_W-1:0] k,
    output pick_t               pick
);

    always_comb begin
        pick = '0;
        unique case (mode)
            MD_SPARSE: begin
                pick.hit = (k[ROW_W-1:0] == '0);
                pick.idx = k[PERIOD_W-1:1];
            end
            MD_DENSE: begin
                pick.hit = (k[ROW_W-1:0] != '1);
                pick.idx = k[ROW_W-1:0];
            end
            MD_HALF: begin
                pick.hit = ~k[0];
                pick.idx = k[PERIOD_W-1:1];
            end
            MD_RAND: begin
                pick.hit = 1'b0;
                pick.idx = '0;
            end
            default: pick = '0;
        endcase
    end

endmodule

// File: rtl/cam_keygen.sv
module cam_keygen
    import cam_keygen_pkg::*;
#(
    parameter logic [KEY_W-1:0] SEED = 18'h1ACE5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [1:0]       mode,
    output logic             wr_o,
    output logic [KEY_W-1:0] data_o,
    output logic [1:0]       phase_o
);

    phase_e              st_q;
    phase_e              ph_q;
    mode_e               mode_q;
    logic [ROW_W-1:0]    cnt_q;
    logic [PERIOD_W-1:0] k_q;
    logic [KEY_W-1:0]    base_q;
    logic                wr_q;
    logic [KEY_W-1:0]    dat_q;

    logic [KEY_W-1:0]    lfsr;
    logic [KEY_W-1:0]    rd;
    logic                we;
    logic [ROW_W-1:0]    waddr;
    logic                wrap;
    logic                adv;
    pick_t               pick;

    assign we    = (st_q == PH_IDLE && start) || (st_q == PH_LOAD);
    assign waddr = (st_q == PH_IDLE) ? '0 : cnt_q;
    assign wrap  = (st_q == PH_SEARCH) && (mode_q != MD_RAND) && (k_q == '1);
    assign adv   = we || (st_q == PH_SEARCH);

    cam_keygen_lfsr #(.SEED(SEED)) u_lfsr (
        .clk        (clk),
        .rst        (rst),
        .advance    (adv),
        .reload     (wrap),
        .reload_val (base_q),
        .state      (lfsr)
    );

    cam_keygen_store u_store (
        .clk   (clk),
        .we    (we),
        .waddr (waddr),
        .wdata (lfsr),
        .raddr (pick.idx),
        .rdata (rd)
    );

    cam_keygen_sched u_sched (
        .mode (mode_q),
        .k    (k_q),
        .pick (pick)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= PH_IDLE;
            ph_q   <= PH_IDLE;
            mode_q <= MD_SPARSE;
            cnt_q  <= '0;
            k_q    <= '0;
            base_q <= '0;
            wr_q   <= 1'b0;
            dat_q  <= '0;
        end else begin
            unique case (st_q)
                PH_IDLE: begin
                    if (start) begin
                        st_q   <= PH_LOAD;
                        ph_q   <= PH_LOAD;
                        mode_q <= mode_e'(mode);
                        wr_q   <= 1'b1;
                        dat_q  <= lfsr;
                        cnt_q  <= ROW_W'(1);
                    end
                end
                PH_LOAD: begin
                    ph_q  <= PH_LOAD;
                    wr_q  <= 1'b0;
                    dat_q <= lfsr;
                    cnt_q <= cnt_q + 1'b1;
                    if (cnt_q == '1) begin
                        st_q   <= PH_SEARCH;
                        k_q    <= '0;
                        base_q <= lfsr_step(lfsr);
                    end
                end
                PH_SEARCH: begin
                    ph_q  <= PH_SEARCH;
                    wr_q  <= 1'b0;
                    dat_q <= pick.hit ? rd : lfsr;
                    k_q   <= k_q + 1'b1;
                end
                default: st_q <= PH_IDLE;
            endcase
        end
    end

    assign wr_o    = wr_q;
    assign data_o  = dat_q;
    assign phase_o = ph_q;

    // checker state: load cycles seen, first search cycle flag
    logic [ROW_W:0] ld_seen;
    logic           srch_seen;
    always_ff @(posedge clk) begin
        if (rst) begin
            ld_seen   <= '0;
            srch_seen <= 1'b0;
        end else begin
            if (ph_q == PH_LOAD) ld_seen <= ld_seen + 1'b1;
            if (ph_q == PH_SEARCH) srch_seen <= 1'b1;
        end
    end

    // R1
    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        (ph_q == PH_IDLE) |-> (!wr_q && dat_q == '0));

    // R2
    a_r2_strobe_single: assert property (@(posedge clk) disable iff (rst)
        wr_q |=> !wr_q);

    // R2
    a_r2_strobe_in_load: assert property (@(posedge clk) disable iff (rst)
        wr_q |-> (ph_q == PH_LOAD));

    // R3
    a_r3_load_length: assert property (@(posedge clk) disable iff (rst)
        (ph_q == PH_SEARCH && !srch_seen) |-> (ld_seen == (ROW_W+1)'(ROWS)));

    // R3
    a_r3_search_sticky: assert property (@(posedge clk) disable iff (rst)
        (ph_q == PH_SEARCH) |=> (ph_q == PH_SEARCH));

    // R9
    a_r9_mode_held: assert property (@(posedge clk) disable iff (rst)
        (st_q != PH_IDLE) |=> $stable(mode_q));

endmodule

// File: tb/test_cam_keygen.sv
module test_cam_keygen;

    localparam logic [17:0] SEED = 18'h1ACE5;
    localparam int NSRCH = 300;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [1:0]  mode = 2'd0;
    logic        wr_o;
    logic [17:0] data_o;
    logic [1:0]  phase_o;

    int n_chk = 0;
    int n_bad = 0;
    logic [17:0] stored [64];
    logic [17:0] hist [NSRCH];

    always #5 clk = ~clk;

    cam_keygen #(.SEED(SEED)) i_cam_keygen (
        .clk(clk), .rst(rst), .start(start), .mode(mode),
        .wr_o(wr_o), .data_o(data_o), .phase_o(phase_o)
    );

    function automatic logic [17:0] nxt(input logic [17:0] s);
        return {s[16:0], s[17] ^ s[10]};
    endfunction

    function automatic bit in_store(input logic [17:0] v);
        for (int i = 0; i < 64; i++) if (stored[i] == v) return 1'b1;
        return 1'b0;
    endfunction

    task automatic chk(input bit ok, input string req, input logic [17:0] act, input logic [17:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic run_mode(input int m, input bit disturb);
        logic [17:0] s, base, miss, rnd, exp;
        bit          hit;
        int          hits;
        rst = 1'b1; start = 1'b0; mode = 2'(m);
        tick(); tick();
        rst = 1'b0;
        for (int i = 0; i < 3; i++) begin
            chk(phase_o == 2'd0 && !wr_o && data_o == 18'd0, "R1 idle", {14'd0, wr_o, 1'b0, phase_o}, 18'd0);
            tick();
        end
        start = 1'b1;
        tick();
        start = 1'b0;
        s = SEED;
        for (int i = 0; i < 64; i++) begin
            if (i > 0) tick();
            stored[i] = s;
            chk(data_o == s, "R2 load word", data_o, s);
            chk(phase_o == 2'd1 && wr_o == (i == 0), "R2 strobe/phase", {15'd0, wr_o, phase_o}, {15'd0, i == 0, 2'd1});
            s = nxt(s);
        end
        base = s; rnd = s; miss = s; hits = 0;
        for (int k = 0; k < NSRCH; k++) begin
            tick();
            if (disturb && k >= 10 && k < 20) begin
                start = 1'b1; mode = 2'(k);
            end else begin
                start = 1'b0;
            end
            if (k % 128 == 0) miss = base;
            case (m)
                0: hit = (k % 64 == 0);
                1: hit = (k % 64 != 63);
                2: hit = (k % 2 == 0);
                default: hit = 1'b0;
            endcase
            if (m == 3) exp = rnd;
            else if (hit) exp = (m == 1) ? stored[k % 64] : stored[(k % 128) / 2];
            else exp = miss;
            chk(phase_o == 2'd2, "R3 search phase", {16'd0, phase_o}, 18'd2);
            case (m)
                0: chk(data_o == exp, disturb ? "R9 sparse key" : "R4 sparse key", data_o, exp);
                1: chk(data_o == exp, disturb ? "R9 dense key" : "R5 dense key", data_o, exp);
                2: chk(data_o == exp, disturb ? "R9 alternating key" : "R6 alternating key", data_o, exp);
                default: chk(data_o == exp, "R8 random key", data_o, exp);
            endcase
            hist[k] = data_o;
            if (m != 3) begin
                chk(in_store(data_o) == hit, "R7 stored membership", data_o, {17'd0, hit});
                if (k >= 128) chk(data_o == hist[k-128], "R7 period 128", data_o, hist[k-128]);
                if (in_store(data_o)) hits++;
                if (k % 64 == 63) begin
                    chk(hits == (m == 0 ? 1 : (m == 1 ? 63 : 32)), "R7 hits per block",
                        18'(hits), 18'(m == 0 ? 1 : (m == 1 ? 63 : 32)));
                    hits = 0;
                end
            end
            miss = nxt(miss);
            rnd  = nxt(rnd);
        end
        start = 1'b0;
    endtask

    initial begin
        tick();
        run_mode(0, 1'b0);
        run_mode(1, 1'b0);
        run_mode(2, 1'b0);
        run_mode(3, 1'b0);
        run_mode(2, 1'b1);
        run_mode(0, 1'b1);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        #2_000_000;
        n_bad++;
        $display("FAIL watchdog expired actual=%0d expected=0", 1);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule